// File: doc/BRIEF.md
# Paired-Word Burst SRAM with Split Data Buses

This block is a synchronous memory that stores words of four 9-bit lanes. Each access moves two words. The caller supplies one pair address, and the block expands it into the word addresses `{pair_addr, 0}` and `{pair_addr, 1}`. The word-address bus is therefore one bit wider inside the block than at its port. Write data comes in on its own bus, and read data leaves on a separate bus, so a read burst can stream out while write beats are being taken.

A command is sampled on a rising edge when `load_n` is low. `rw_sel` high requests a read and `rw_sel` low requests a write. Write data beats, and the per-beat lane enables that go with them, are taken on the two edges that follow the command. Read words leave through a registered pipeline at a fixed latency. A command that arrives on the edge right after an accepted command is refused and flagged. Every later read sees every earlier write in full, including a read that is issued on the same edge as the last beat of a write.

Top module: `pairburst_sram`

## Requirements
- R1: After reset, and until the first read word arrives, `rvalid`, `cmd_err` and `rdata` are all 0.
- R2: A write command (`load_n`=0, `rw_sel`=0, accepted on edge N) stores the `wdata` sampled at edge N+1 into word `{pair_addr,0}` and the `wdata` sampled at edge N+2 into word `{pair_addr,1}`.
- R3: Bit i of `lane_we_n` is active low and guards data bits 9i to 9i+8. A lane whose enable is high keeps its previous contents.
- R4: The lane enables are sampled with each data beat, so the two beats of one write can use different masks.
- R5: A read command accepted on edge N drives word `{pair_addr,0}` on `rdata` from edge N+2 and word `{pair_addr,1}` from edge N+3. `rvalid` is 1 for exactly those two cycles.
- R6: A command can be accepted every second edge. Reads issued at that rate produce an unbroken stream of valid words.
- R7: A read accepted on the edge that takes the second beat of a write to the same pair returns the newly written data for both words.
- R8: A command on the edge right after an accepted command is ignored. It changes no memory word and produces no read output, and `cmd_err` is 1 for the single cycle after that edge.
- R9: While `load_n` is high and no burst is in progress, `wdata` and `lane_we_n` have no effect on memory.
- R10: Read output beats and write input beats can occur in the same cycle without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Command strobe, active low |
| rw_sel | input | 1 | 1 = read, 0 = write |
| pair_addr | input | ADDR_W | Pair address, which selects two adjacent words |
| wdata | input | LANES*LANE_W | Write data beat |
| lane_we_n | input | LANES | Per-lane write enables for the current beat, active low |
| rdata | output | LANES*LANE_W | Read data beat |
| rvalid | output | 1 | High while `rdata` carries a read word |
| cmd_err | output | 1 | One-cycle flag for a refused command |

## Verification
Two pairs of functions can fall in the same cycle. The first is the final write beat landing while a new command is accepted. The bench provokes this by issuing a read of the pair being written on the edge that takes its second beat, and judges it by comparing both returned words against a reference memory updated from R2 to R4. The second is a read burst leaving on `rdata` while a write burst is arriving on `wdata`. The bench provokes this by issuing a write two edges after a read. A scoreboard then checks each streamed word's cycle and value, and a later read-back confirms that the write landed intact.

// File: rtl/pb_pkg.sv
package pb_pkg;
   typedef enum logic {
      PB_OP_WRITE = 1'b0,
      PB_OP_READ  = 1'b1
   } pb_op_e;

   localparam int PB_BEATS = 2;
endpackage

// File: rtl/pb_seq.sv
module pb_seq
   import pb_pkg::*;
#(
   parameter int ADDR_W = 4,
   localparam int WA = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic              rw_sel,
   input  logic [ADDR_W-1:0] pair_addr,
   output logic              acc_en,
   output logic              acc_wr,
   output logic [WA-1:0]     acc_addr,
   output logic              cmd_err
);
   logic              ph1_q, ph2_q;
   pb_op_e            op1_q, op2_q;
   logic [ADDR_W-1:0] base1_q, base2_q;
   logic              err_q;
   logic              accept;

   assign accept = !load_n && !ph1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph1_q   <= 1'b0;
         ph2_q   <= 1'b0;
         op1_q   <= PB_OP_READ;
         op2_q   <= PB_OP_READ;
         base1_q <= '0;
         base2_q <= '0;
         err_q   <= 1'b0;
      end else begin
         ph2_q   <= ph1_q;
         op2_q   <= op1_q;
         base2_q <= base1_q;
         ph1_q   <= accept;
         err_q   <= !load_n && ph1_q;
         if (accept) begin
            op1_q   <= rw_sel ? PB_OP_READ : PB_OP_WRITE;
            base1_q <= pair_addr;
         end
      end
   end

   always_comb begin
      acc_en   = ph1_q || ph2_q;
      acc_wr   = ph1_q ? (op1_q == PB_OP_WRITE) : (ph2_q && op2_q == PB_OP_WRITE);
      acc_addr = ph1_q ? {base1_q, 1'b0} : {base2_q, 1'b1};
   end

   assign cmd_err = err_q;

   // R2: the first beat is always followed by the second
   a_r2_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
      ph1_q |=> ph2_q);
   // R6: one array access per cycle
   a_r6_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ph1_q, ph2_q}));
   // R8: a refusal flag only follows a busy first-beat cycle
   a_r8_err_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(ph1_q));
endmodule

// File: rtl/pb_lane_array.sv
module pb_lane_array #(
   parameter int WA     = 5,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << WA
) (
   input  logic             clk,
   input  logic             acc_en,
   input  logic             acc_wr,
   input  logic [WA-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic [LANES-1:0] lane_we_n,
   output logic [DW-1:0]    rd_word
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic              lane_wr;

      assign lane_wr = acc_en && acc_wr && !lane_we_n[l];

      always_ff @(posedge clk) begin
         if (lane_wr) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rd_word[l*LANE_W +: LANE_W] = mem[addr];
   end
endmodule

// File: rtl/pb_rd_pipe.sv
module pb_rd_pipe #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic [DW-1:0] word,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);
   logic [DW-1:0] stage_q, out_q;
   logic          stage_v, out_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         stage_v <= 1'b0;
         out_q   <= '0;
         out_v   <= 1'b0;
      end else begin
         stage_v <= fire;
         if (fire) stage_q <= word;
         out_v <= stage_v;
         if (stage_v) out_q <= stage_q;
      end
   end

   assign rdata  = out_q;
   assign rvalid = out_v;

   // R5: read words always leave in pairs
   a_r5_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |=> rvalid);
   // R5: an output beat always comes from a staged array read
   a_r5_staged: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> $past(stage_v));
endmodule

// File: rtl/pairburst_sram.sv
module pairburst_sram
   import pb_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W,
   localparam int WA    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic              rw_sel,
   input  logic [ADDR_W-1:0] pair_addr,
   input  logic [DW-1:0]     wdata,
   input  logic [LANES-1:0]  lane_we_n,
   output logic [DW-1:0]     rdata,
   output logic              rvalid,
   output logic              cmd_err
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("pairburst_sram: ADDR_W out of range");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("pairburst_sram: lane geometry must be positive");
   end
   if (PB_BEATS != 2) begin : g_bad_beats
      $error("pairburst_sram: burst length fixed at two");
   end

   logic          acc_en, acc_wr;
   logic [WA-1:0] acc_addr;
   logic [DW-1:0] rd_word;

   pb_seq #(.ADDR_W(ADDR_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_n   (load_n),
      .rw_sel   (rw_sel),
      .pair_addr(pair_addr),
      .acc_en   (acc_en),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .cmd_err  (cmd_err)
   );

   pb_lane_array #(.WA(WA), .LANES(LANES), .LANE_W(LANE_W)) array_i (
      .clk      (clk),
      .acc_en   (acc_en),
      .acc_wr   (acc_wr),
      .addr     (acc_addr),
      .wdata    (wdata),
      .lane_we_n(lane_we_n),
      .rd_word  (rd_word)
   );

   pb_rd_pipe #(.DW(DW)) pipe_i (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (acc_en && !acc_wr),
      .word  (rd_word),
      .rdata (rdata),
      .rvalid(rvalid)
   );

   // R8: a refused command never opens a read burst in the next cycle
   a_r8_no_read_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> !(acc_en && !acc_wr && acc_addr[0] == 1'b0));
endmodule

// File: tb/pairburst_sram_tb_top.sv
`timescale 1ns/1ps
module pairburst_sram_tb_top;
   localparam int AW = 4;
   localparam int DW = 36;
   localparam int NW = 1 << (AW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_n = 1'b1;
   logic          rw_sel = 1'b1;
   logic [AW-1:0] pair_addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [3:0]    lane_we_n = 4'hF;
   logic [DW-1:0] rdata;
   logic          rvalid, cmd_err;

   always #4 clk = ~clk;

   pairburst_sram dut_i (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .rw_sel(rw_sel),
      .pair_addr(pair_addr), .wdata(wdata), .lane_we_n(lane_we_n),
      .rdata(rdata), .rvalid(rvalid), .cmd_err(cmd_err)
   );

   typedef struct {
      int          due;
      logic [DW-1:0] data;
      int          req;
   } exp_t;

   exp_t          sb[$];
   logic [DW-1:0] ref_mem [NW];
   int            cyc = 0;
   int            checks = 0;
   int            errors = 0;
   int            cur_req = 5;
   bit            run = 0;
   bit            done = 0;

   // bench protocol model
   bit            m_ph1 = 0, m_ph2 = 0, m_wr1 = 0, m_wr2 = 0;
   logic [AW-1:0] m_b1 = '0, m_b2 = '0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare streamed read words with the scoreboard
   always @(negedge clk) begin
      if (run) begin
         if (rvalid) begin
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R8 unexpected rvalid at cycle %0d: actual data %h expected no output", cyc, rdata);
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (e.due != cyc || rdata !== e.data) begin
                  errors++;
                  $display("FAIL R%0d read word: actual cycle %0d data %h expected cycle %0d data %h",
                           e.req, cyc, rdata, e.due, e.data);
               end
            end
         end else if (sb.size() != 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            errors++;
            $display("FAIL R5 missing read word: actual rvalid 0 at cycle %0d expected data %h", cyc, e.data);
         end
      end
   end

   function automatic void apply_beat(logic [AW-1:0] b, bit lsb, logic [DW-1:0] d, logic [3:0] m);
      for (int l = 0; l < 4; l++)
         if (!m[l]) ref_mem[{b, lsb}][l*9 +: 9] = d[l*9 +: 9];
   endfunction

   // driver: one cycle of stimulus, model update and refusal check (R8)
   task automatic tick(bit ln, bit rw, logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] m);
      bit exp_err, acc;
      load_n = ln; rw_sel = rw; pair_addr = a; wdata = d; lane_we_n = m;
      exp_err = !ln && m_ph1;
      acc     = !ln && !m_ph1;
      if (m_ph1 && m_wr1) apply_beat(m_b1, 1'b0, d, m);
      if (m_ph2 && m_wr2) apply_beat(m_b2, 1'b1, d, m);
      if (acc && rw) begin
         sb.push_back('{due: cyc + 3, data: ref_mem[{a, 1'b0}], req: cur_req});
         sb.push_back('{due: cyc + 4, data: ref_mem[{a, 1'b1}], req: cur_req});
      end
      m_ph2 = m_ph1; m_wr2 = m_wr1; m_b2 = m_b1;
      m_ph1 = acc; m_wr1 = !rw; m_b1 = a;
      @(negedge clk);
      checks++;
      if (cmd_err !== exp_err) begin
         errors++;
         $display("FAIL R8 cmd_err: actual %0b expected %0b at cycle %0d", cmd_err, exp_err, cyc);
      end
   endtask

   function automatic logic [DW-1:0] pat();
      return {$urandom, $urandom} & {DW{1'b1}};
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick(1, 1, '0, pat(), 4'h0);
   endtask

   task automatic write_pair(logic [AW-1:0] a, logic [3:0] m0, logic [3:0] m1);
      tick(0, 0, a, pat(), 4'h0);
      tick(1, 0, '0, pat(), m0);
      tick(1, 0, '0, pat(), m1);
   endtask

   task automatic read_pair(logic [AW-1:0] a);
      tick(0, 1, a, pat(), 4'hF);
      tick(1, 1, '0, pat(), 4'hF);
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (rvalid !== 1'b0 || cmd_err !== 1'b0 || rdata !== '0) begin
         errors++;
         $display("FAIL R1 reset outputs: actual rvalid %0b err %0b data %h expected 0 0 0", rvalid, cmd_err, rdata);
      end
      run = 1;

      // R2: fill all pairs with full-lane writes
      cur_req = 2;
      for (int p = 0; p < (1 << AW); p++) write_pair(p[AW-1:0], 4'h0, 4'h0);
      idle(2);
      // R5 / R6: back-to-back reads stream without gaps
      cur_req = 6;
      for (int p = 0; p < 8; p++) read_pair(p[AW-1:0]);
      idle(4);

      // R3 / R4: different lane masks per beat
      cur_req = 4;
      write_pair(4'd2, 4'b1010, 4'b0101);
      write_pair(4'd9, 4'b1111, 4'b0000);
      idle(1);
      cur_req = 3;
      read_pair(4'd2);
      read_pair(4'd9);
      idle(4);

      // R9: strobe high, data and masks wiggle
      idle(5);
      cur_req = 9;
      read_pair(4'd3);
      idle(4);

      // R7: read issued with the second write beat
      cur_req = 7;
      tick(0, 0, 4'd4, pat(), 4'h0);
      tick(1, 0, '0, pat(), 4'h0);
      tick(0, 1, 4'd4, pat(), 4'b0110);
      tick(1, 1, '0, pat(), 4'h0);
      idle(4);

      // R10: read output overlaps write beats
      cur_req = 10;
      tick(0, 1, 4'd5, pat(), 4'hF);
      tick(1, 1, '0, pat(), 4'hF);
      write_pair(4'd6, 4'h0, 4'b1100);
      read_pair(4'd6);
      idle(4);

      // R8: refused read during a write, refused write during a read
      cur_req = 8;
      tick(0, 0, 4'd7, pat(), 4'h0);
      tick(0, 1, 4'd1, pat(), 4'h0);
      tick(1, 0, '0, pat(), 4'h0);
      idle(3);
      tick(0, 1, 4'd0, pat(), 4'hF);
      tick(0, 0, 4'd0, pat(), 4'h0);
      tick(1, 0, '0, pat(), 4'h0);
      tick(1, 0, '0, pat(), 4'h0);
      idle(3);
      read_pair(4'd7);
      read_pair(4'd1);
      read_pair(4'd0);
      idle(6);

      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R5 leftover expected words: actual %0d expected 0", sb.size());
      end
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end
endmodule